// File: doc/BRIEF.md
# Multi-Port Interrupt Cause Aggregator with Pin Steering

This block gathers interrupt causes for every port of a multi-port storage host controller. Each port holds six sticky cause bits, which one-cycle event pulses from the protocol side set. The cause bits are command done, command failed, link-ready rising, power-state change, PHY state change and wake signal received. Software clears a cause by writing ones into the status register. Command-done can instead be cleared as a side effect of reading a slot register. Each cause has its own enable. The enabled causes of a port fold into one port interrupt, and a per-port 2-bit route field sends that interrupt onto one of four shared pins. Each pin is the wired OR of every port routed to it.

The block also keeps a per-port link-ready flag. A command failure drops the flag, and new work must not be issued while it is low. Software restarts the port with an initialise request. The flag returns once a parameterised delay has elapsed, and that 0-to-1 change raises its own cause bit. Access goes through a plain strobe bus: one write strobe and one read strobe, with read data returned one cycle later. The address is `{port, reg[2:0]}`. Register selects are 0 status, 1 enable-set, 2 enable-clear, 3 control, 4 link status, 5 slot.

Top module: `port_irq_hub`

## Requirements
- R1: Event pulses latch sticky status bits, one per cause: bit 0 command done, bit 1 command failed, bit 2 link-ready rising, bit 3 power-state change, bit 4 PHY change, bit 5 wake received. A status read returns these six bits both at [5:0] and at [21:16], with all other bits zero.
- R2: Writing the status register clears cause k when bit k or bit k+16 of the write data is one. Zero bits in the write data leave the status unchanged.
- R3: When an event pulse and a clear of the same cause fall in the same cycle, the cause ends up set.
- R4: Control bit 3 selects how command done is cleared. With the bit at 0, a read of the slot register clears status bit 0. With the bit at 1, a slot read leaves it set and only a write-one clears it.
- R5: A write to enable-set sets the enables at data bits [5:0] that are one. A write to enable-clear clears them. The port interrupt is the OR of the status bits ANDed with their enables. Reading either enable register returns the enables at [5:0].
- R6: A write to either enable register loads the port's route field from data bits [31:30], where 0, 1, 2 and 3 select pins 0, 1, 2 and 3. The field reads back at [31:30]. Each pin is the OR of the interrupts of the ports routed to it.
- R7: A command-failed pulse forces that port's link-ready output, and bit 31 of its link status register, to 0 at the same clock edge at which the cause latches.
- R8: Writing a one to control bit 2 starts initialisation. Exactly INIT_CYCLES clock edges after the write edge, link-ready becomes 1 and status bit 1 is cleared.
- R9: Status bit 2 sets only when link-ready goes from 0 to 1. An initialisation that completes while the port is already ready leaves it unchanged.
- R10: After reset, all status bits, enables, route fields, control bits and link-ready flags are 0, and all four pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | {port index, register select} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| ev_done | input | NUM_PORTS | Command-done event pulses |
| ev_err | input | NUM_PORTS | Command-failed event pulses |
| ev_pm | input | NUM_PORTS | Power-state change pulses |
| ev_phy | input | NUM_PORTS | PHY state change pulses |
| ev_wake | input | NUM_PORTS | Wake-received pulses |
| port_ready | output | NUM_PORTS | Per-port link-ready flag |
| irq_pin | output | 4 | Shared interrupt pins |

## Verification
The bench builds the block with NUM_PORTS = 3 and INIT_CYCLES = 5. Three ports cannot fill the four pins one to one, and the port field has an address code with no port behind it. With three ports the random route mix regularly puts two ports on one pin and leaves another pin idle. An initialisation window of five cycles is short enough that the exact completion edge can be probed from both sides. It also lets every port be brought up before a random phase of several hundred cycles.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int CAUSE_N  = 6;
   localparam int PIN_N    = 4;
   localparam int ROUTE_W  = 2;
   localparam int SEL_W    = 3;

   localparam int C_DONE = 0;
   localparam int C_ERR  = 1;
   localparam int C_RDY  = 2;
   localparam int C_PM   = 3;
   localparam int C_PHY  = 4;
   localparam int C_WAKE = 5;

   localparam int ALIAS_OFS     = 16;
   localparam int ROUTE_LSB     = 30;
   localparam int CTL_INIT_BIT  = 2;
   localparam int CTL_MODE_BIT  = 3;
   localparam int READY_BIT     = 31;

   typedef logic [CAUSE_N-1:0] cause_t;
   typedef logic [ROUTE_W-1:0] route_t;

   typedef enum logic [SEL_W-1:0] {
      SEL_STAT   = 3'd0,
      SEL_EN_SET = 3'd1,
      SEL_EN_CLR = 3'd2,
      SEL_CTRL   = 3'd3,
      SEL_LINK   = 3'd4,
      SEL_SLOT   = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/pirq_cause_bank.sv
module pirq_cause_bank
   import pirq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  cause_t set_i,
   input  cause_t clr_i,
   input  cause_t en_set_i,
   input  cause_t en_clr_i,
   input  logic   route_we_i,
   input  route_t route_d_i,
   output cause_t stat_o,
   output cause_t en_o,
   output route_t route_o,
   output logic   irq_o
);
   cause_t stat_q;
   cause_t en_q;
   route_t route_q;

   for (genvar k = 0; k < CAUSE_N; k++) begin : g_bit
      // a pulse in the same cycle as a clear keeps the cause
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           stat_q[k] <= 1'b0;
         else if (set_i[k])    stat_q[k] <= 1'b1;
         else if (clr_i[k])    stat_q[k] <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            en_q[k] <= 1'b0;
         else if (en_set_i[k])  en_q[k] <= 1'b1;
         else if (en_clr_i[k])  en_q[k] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          route_q <= '0;
      else if (route_we_i) route_q <= route_d_i;
   end

   assign stat_o  = stat_q;
   assign en_o    = en_q;
   assign route_o = route_q;
   assign irq_o   = |(stat_q & en_q);
endmodule

// File: rtl/pirq_ready_ctl.sv
module pirq_ready_ctl #(
   parameter int INIT_CYCLES = 16,
   localparam int CNT_W = $clog2(INIT_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init_req_i,
   input  logic fail_i,
   output logic ready_o,
   output logic busy_o,
   output logic done_o,
   output logic rise_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             ready_q;
   logic             done;

   assign done = busy_q && (cnt_q == CNT_W'(1)) && !init_req_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (init_req_i) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(INIT_CYCLES);
      end else if (busy_q) begin
         cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ready_q <= 1'b0;
      else if (fail_i)  ready_q <= 1'b0;
      else if (done)    ready_q <= 1'b1;
   end

   assign ready_o = ready_q;
   assign busy_o  = busy_q;
   assign done_o  = done;
   assign rise_o  = done && !ready_q && !fail_i;
endmodule

// File: rtl/pirq_pin_router.sv
module pirq_pin_router
   import pirq_pkg::*;
#(
   parameter int NUM_PORTS = 4
) (
   input  logic [NUM_PORTS-1:0]         port_irq_i,
   input  logic [NUM_PORTS*ROUTE_W-1:0] route_i,
   output logic [PIN_N-1:0]             pin_o
);
   for (genvar j = 0; j < PIN_N; j++) begin : g_pin
      logic acc;
      always_comb begin
         acc = 1'b0;
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (route_i[p*ROUTE_W +: ROUTE_W] == ROUTE_W'(j))
               acc = acc | port_irq_i[p];
         end
      end
      assign pin_o[j] = acc;
   end
endmodule

// File: rtl/port_irq_hub.sv
module port_irq_hub
   import pirq_pkg::*;
#(
   parameter int NUM_PORTS   = 4,
   parameter int INIT_CYCLES = 16,
   parameter bit RDATA_REG   = 1'b1,
   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int ADDR_W = PORT_W + SEL_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NUM_PORTS-1:0] ev_done,
   input  logic [NUM_PORTS-1:0] ev_err,
   input  logic [NUM_PORTS-1:0] ev_pm,
   input  logic [NUM_PORTS-1:0] ev_phy,
   input  logic [NUM_PORTS-1:0] ev_wake,
   output logic [NUM_PORTS-1:0] port_ready,
   output logic [PIN_N-1:0]     irq_pin
);
   if (NUM_PORTS < 1 || NUM_PORTS > 16) begin : g_bad_ports
      $error("port_irq_hub: NUM_PORTS must lie in 1..16");
   end
   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("port_irq_hub: INIT_CYCLES must be at least 1");
   end

   logic [PORT_W-1:0] adr_port;
   reg_sel_e          adr_sel;
   logic              port_valid;
   cause_t            w1c_mask;

   assign adr_port   = bus_addr[ADDR_W-1:SEL_W];
   assign adr_sel    = reg_sel_e'(bus_addr[SEL_W-1:0]);
   assign port_valid = (32'(adr_port) < 32'(NUM_PORTS));
   assign w1c_mask   = bus_wdata[CAUSE_N-1:0] | bus_wdata[ALIAS_OFS +: CAUSE_N];

   cause_t  stat_a  [NUM_PORTS];
   cause_t  en_a    [NUM_PORTS];
   route_t  route_a [NUM_PORTS];
   logic [NUM_PORTS-1:0]         mode_q;
   logic [NUM_PORTS-1:0]         init_busy;
   logic [NUM_PORTS-1:0]         port_irq;
   logic [NUM_PORTS*ROUTE_W-1:0] route_flat;
   logic [NUM_PORTS*CAUSE_N-1:0] stat_flat;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic   hit;
      logic   wr_stat, wr_en_set, wr_en_clr, wr_ctrl, rd_slot;
      logic   init_done, ready_rise;
      cause_t set_v, clr_v;

      assign hit       = port_valid && (adr_port == PORT_W'(p));
      assign wr_stat   = bus_wr && hit && (adr_sel == SEL_STAT);
      assign wr_en_set = bus_wr && hit && (adr_sel == SEL_EN_SET);
      assign wr_en_clr = bus_wr && hit && (adr_sel == SEL_EN_CLR);
      assign wr_ctrl   = bus_wr && hit && (adr_sel == SEL_CTRL);
      assign rd_slot   = bus_rd && hit && (adr_sel == SEL_SLOT);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       mode_q[p] <= 1'b0;
         else if (wr_ctrl) mode_q[p] <= bus_wdata[CTL_MODE_BIT];
      end

      pirq_ready_ctl #(.INIT_CYCLES(INIT_CYCLES)) i_ready (
         .clk       (clk),
         .rst_n     (rst_n),
         .init_req_i(wr_ctrl && bus_wdata[CTL_INIT_BIT]),
         .fail_i    (ev_err[p]),
         .ready_o   (port_ready[p]),
         .busy_o    (init_busy[p]),
         .done_o    (init_done),
         .rise_o    (ready_rise)
      );

      always_comb begin
         set_v          = '0;
         set_v[C_DONE]  = ev_done[p];
         set_v[C_ERR]   = ev_err[p];
         set_v[C_RDY]   = ready_rise;
         set_v[C_PM]    = ev_pm[p];
         set_v[C_PHY]   = ev_phy[p];
         set_v[C_WAKE]  = ev_wake[p];

         clr_v = wr_stat ? w1c_mask : '0;
         if (rd_slot && !mode_q[p]) clr_v[C_DONE] = 1'b1;
         if (init_done)             clr_v[C_ERR]  = 1'b1;
      end

      pirq_cause_bank i_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_i     (set_v),
         .clr_i     (clr_v),
         .en_set_i  (wr_en_set ? bus_wdata[CAUSE_N-1:0] : '0),
         .en_clr_i  (wr_en_clr ? bus_wdata[CAUSE_N-1:0] : '0),
         .route_we_i(wr_en_set || wr_en_clr),
         .route_d_i (bus_wdata[ROUTE_LSB +: ROUTE_W]),
         .stat_o    (stat_a[p]),
         .en_o      (en_a[p]),
         .route_o   (route_a[p]),
         .irq_o     (port_irq[p])
      );

      assign route_flat[p*ROUTE_W +: ROUTE_W] = route_a[p];
      assign stat_flat[p*CAUSE_N +: CAUSE_N]  = stat_a[p];
   end

   pirq_pin_router #(.NUM_PORTS(NUM_PORTS)) i_router (
      .port_irq_i(port_irq),
      .route_i   (route_flat),
      .pin_o     (irq_pin)
   );

   logic [31:0] rd_val;
   always_comb begin
      rd_val = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (port_valid && adr_port == PORT_W'(p)) begin
            case (adr_sel)
               SEL_STAT:   rd_val = {10'b0, stat_a[p], 10'b0, stat_a[p]};
               SEL_EN_SET,
               SEL_EN_CLR: rd_val = {route_a[p], 24'b0, en_a[p]};
               SEL_CTRL:   rd_val = {28'b0, mode_q[p], 3'b0};
               SEL_LINK:   rd_val = {port_ready[p], 30'b0, init_busy[p]};
               SEL_SLOT:   rd_val = {31'b0, stat_a[p][C_DONE]};
               default:    rd_val = '0;
            endcase
         end
      end
   end

   if (RDATA_REG) begin : g_rd_flop
      logic [31:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      rdata_q <= '0;
         else if (bus_rd) rdata_q <= rd_val;
      end
      assign bus_rdata = rdata_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_val;
   end
endmodule

// File: rtl/pirq_checker.sv
module pirq_checker #(
   parameter int NUM_PORTS = 4,
   parameter int CN        = 6
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_PORTS-1:0]    ev_err,
   input logic [NUM_PORTS-1:0]    ev_pm,
   input logic [NUM_PORTS-1:0]    port_ready,
   input logic [NUM_PORTS-1:0]    init_busy,
   input logic [NUM_PORTS-1:0]    port_irq,
   input logic [NUM_PORTS*CN-1:0] stat_flat,
   input logic [3:0]              irq_pin
);
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
      assert_fail_latches_R1: assert property (@(posedge clk) disable iff (!rst_n)
         ev_err[p] |=> stat_flat[p*CN + 1]);
      assert_pulse_beats_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
         ev_pm[p] |=> stat_flat[p*CN + 3]);
      assert_fail_drops_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ev_err[p] |=> !port_ready[p]);
      assert_ready_needs_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(port_ready[p]) |-> $past(init_busy[p]));
      assert_rise_sets_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(port_ready[p]) |-> stat_flat[p*CN + 2]);
   end

   assert_pins_track_ports_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_pin) == (|port_irq));
endmodule

bind port_irq_hub pirq_checker #(.NUM_PORTS(NUM_PORTS), .CN(pirq_pkg::CAUSE_N)) i_pirq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_err    (ev_err),
   .ev_pm     (ev_pm),
   .port_ready(port_ready),
   .init_busy (init_busy),
   .port_irq  (port_irq),
   .stat_flat (stat_flat),
   .irq_pin   (irq_pin)
);

// File: tb/test_port_irq_hub.sv
`timescale 1ns/1ps
module test_port_irq_hub;
   localparam int NP   = 3;
   localparam int INIT = 5;
   localparam int PW   = 2;
   localparam int AW   = PW + 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] ev_done = '0, ev_err = '0, ev_pm = '0, ev_phy = '0, ev_wake = '0;
   logic [NP-1:0] port_ready;
   logic [3:0]    irq_pin;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   port_irq_hub #(.NUM_PORTS(NP), .INIT_CYCLES(INIT), .RDATA_REG(1'b1)) i_port_irq_hub (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_done(ev_done), .ev_err(ev_err),
      .ev_pm(ev_pm), .ev_phy(ev_phy), .ev_wake(ev_wake), .port_ready(port_ready),
      .irq_pin(irq_pin)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] adr(input int p, input int sel);
      return {PW'(p), 3'(sel)};
   endfunction

   // one clock cycle of stimulus; starts and returns at a falling edge
   task automatic cyc(input logic wr, input logic rd, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic [NP-1:0] dn, input logic [NP-1:0] er,
                      input logic [NP-1:0] pm, input logic [NP-1:0] ph, input logic [NP-1:0] wk);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      ev_done = dn; ev_err = er; ev_pm = pm; ev_phy = ph; ev_wake = wk;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
      ev_done = '0; ev_err = '0; ev_pm = '0; ev_phy = '0; ev_wake = '0;
   endtask

   task automatic idle(); cyc(0, 0, '0, '0, '0, '0, '0, '0, '0); endtask
   task automatic wreg(input int p, input int s, input logic [31:0] d);
      cyc(1, 0, adr(p, s), d, '0, '0, '0, '0, '0);
   endtask
   task automatic rreg(input int p, input int s);
      cyc(0, 1, adr(p, s), '0, '0, '0, '0, '0, '0);
   endtask

   // bench model for the random phase
   logic [5:0] m_stat [NP];
   logic [5:0] m_en   [NP];
   logic [1:0] m_rt   [NP];
   logic       m_mode [NP];
   logic       m_rdy  [NP];

   function automatic logic [3:0] exp_pins();
      logic [3:0] r = '0;
      for (int q = 0; q < NP; q++)
         if (|(m_stat[q] & m_en[q])) r[m_rt[q]] = 1'b1;
      return r;
   endfunction

   initial begin
      #(200000 * 20);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [NP-1:0] one0;
      int unused_seed;
      one0 = NP'(1);
      unused_seed = $urandom(32'h1d5a);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      chk("R10 pins", 32'(irq_pin), 0);
      chk("R10 ready", 32'(port_ready), 0);
      rreg(0, 0); chk("R10 status", bus_rdata, 0);
      rreg(2, 1); chk("R10 enables/route", bus_rdata, 0);

      // R8/R9: initialise port 0, exact completion edge
      wreg(0, 3, 32'h4);
      repeat (INIT - 1) idle();
      chk("R8 not yet ready", 32'(port_ready[0]), 0);
      idle();
      chk("R8 ready after INIT_CYCLES", 32'(port_ready[0]), 1);
      rreg(0, 4); chk("R8 link bit31", bus_rdata, 32'h8000_0000);
      rreg(0, 0); chk("R9 rise cause / R1 mirror", bus_rdata, 32'h0004_0004);

      // R2: zero write no effect, alias bit 18 clears cause 2
      wreg(0, 0, 32'h0);
      rreg(0, 0); chk("R2 zero write", bus_rdata, 32'h0004_0004);
      wreg(0, 0, 32'h0004_0000);
      rreg(0, 0); chk("R2 alias clear", bus_rdata, 0);

      // R9: init while ready does not set cause 2
      wreg(0, 3, 32'h4);
      repeat (INIT + 1) idle();
      rreg(0, 0); chk("R9 no re-rise", bus_rdata, 0);
      chk("R9 still ready", 32'(port_ready[0]), 1);

      // R5/R6: enable power-state cause on port 0, route to pin 2
      wreg(0, 1, 32'h8000_0008);
      chk("R6 no pin yet", 32'(irq_pin), 0);
      cyc(0, 0, '0, '0, '0, '0, one0, '0, '0);
      chk("R6 pin 2", 32'(irq_pin), 32'h4);
      rreg(0, 1); chk("R6 route readback", bus_rdata, 32'h8000_0008);
      wreg(0, 2, 32'h8000_0008);
      chk("R5 enable clear masks", 32'(irq_pin), 0);
      wreg(0, 0, 32'h8);

      // R7/R8: command failure drops ready, init restores it and clears cause 1
      cyc(0, 0, '0, '0, '0, one0, '0, '0, '0);
      chk("R7 ready dropped", 32'(port_ready[0]), 0);
      rreg(0, 4); chk("R7 link bit31 low", bus_rdata, 0);
      rreg(0, 0); chk("R1 fail cause", bus_rdata, 32'h0002_0002);
      wreg(0, 3, 32'h4);
      repeat (INIT) idle();
      chk("R8 ready restored", 32'(port_ready[0]), 1);
      rreg(0, 0); chk("R8 fail cleared, R9 rise", bus_rdata, 32'h0004_0004);

      // R3: wake pulse and its clear in the same cycle
      cyc(1, 0, adr(1, 0), 32'h0000_0020, '0, '0, '0, '0, NP'(2));
      rreg(1, 0); chk("R3 set wins", bus_rdata, 32'h0020_0020);
      wreg(1, 0, 32'h20);

      // R4: slot read clears done in mode 0, not in mode 1
      cyc(0, 0, '0, '0, NP'(2), '0, '0, '0, '0);
      rreg(1, 5); chk("R4 slot shows done", bus_rdata, 1);
      rreg(1, 0); chk("R4 cleared by slot read", bus_rdata, 0);
      wreg(1, 3, 32'h8);
      cyc(0, 0, '0, '0, NP'(2), '0, '0, '0, '0);
      rreg(1, 5);
      rreg(1, 0); chk("R4 kept in mode 1", bus_rdata, 32'h0001_0001);
      wreg(1, 0, 32'h0001_0000);
      rreg(1, 0); chk("R4 write-one clears", bus_rdata, 0);

      // random phase against the bench model
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int q = 0; q < NP; q++) begin
         m_stat[q] = 6'h04; m_en[q] = '0; m_rt[q] = '0; m_mode[q] = 1'b0; m_rdy[q] = 1'b1;
         wreg(q, 3, 32'h4);
      end
      repeat (INIT) idle();

      for (int it = 0; it < 800; it++) begin
         logic [NP-1:0] dn, er, pm, ph, wk;
         logic [31:0] d, exp_rd;
         logic wr, rd;
         int p, op, sel;
         for (int q = 0; q < NP; q++) begin
            dn[q] = ($urandom % 6) == 0;
            er[q] = ($urandom % 20) == 0;
            pm[q] = ($urandom % 8) == 0;
            ph[q] = ($urandom % 8) == 0;
            wk[q] = ($urandom % 8) == 0;
         end
         p  = $urandom % NP;
         op = $urandom % 7;
         d  = $urandom;
         if (op == 6) d[2] = 1'b0;
         wr = (op == 1 || op == 2 || op == 3 || op == 6);
         rd = (op == 4 || op == 5);
         case (op)
            1: sel = 0; 2: sel = 1; 3: sel = 2; 4: sel = 5; 5: sel = 0; 6: sel = 3;
            default: sel = 0;
         endcase
         exp_rd = {10'b0, m_stat[p], 10'b0, m_stat[p]};
         for (int q = 0; q < NP; q++) begin
            logic [5:0] c, s;
            c = '0;
            if (q == p && op == 1) c = d[5:0] | d[21:16];
            if (q == p && op == 4 && !m_mode[q]) c[0] = 1'b1;
            s = {wk[q], ph[q], pm[q], 1'b0, er[q], dn[q]};
            m_stat[q] = (m_stat[q] & ~c) | s;
            if (q == p && op == 2) begin m_en[q] = m_en[q] | d[5:0];  m_rt[q] = d[31:30]; end
            if (q == p && op == 3) begin m_en[q] = m_en[q] & ~d[5:0]; m_rt[q] = d[31:30]; end
            if (q == p && op == 6) m_mode[q] = d[3];
            if (er[q]) m_rdy[q] = 1'b0;
         end
         cyc(wr, rd, adr(p, sel), d, dn, er, pm, ph, wk);
         if (op == 5) chk("R1/R2/R3/R4 random status", bus_rdata, exp_rd);
         chk("R5/R6 random pins", 32'(irq_pin), 32'(exp_pins()));
         for (int q = 0; q < NP; q++)
            chk("R7 random ready", 32'(port_ready[q]), 32'(m_rdy[q]));
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule